// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes a `W`-bit word between two buses, A and B, in one direction at a time. Each side has its own storage register with its own capture clock. The A-side register samples the A bus and the B-side register samples the B bus, on the rising edge of their clocks. Capture is never gated: a word present at a bus is stored on every rising edge of the matching clock, whatever the enable and direction inputs say.

An active-low enable and a direction input decide which bus, if any, is driven. One of three states results: isolation, driving A, or driving B. For each direction, a source select picks what goes out: either the live word from the opposite bus or the word held in the opposite side's register. The chosen word leaves complemented.

Each bus is modelled as three separate vectors: an input, an output and an output enable. The output side is purely combinational, so a change on a live input or on a select shows at the driven bus without waiting for a clock. No data flows as a stream here, so the pins are plain levels with no valid/ready handshake and no back-pressure.

Top module: `xcvr_regbus`

## Requirements
- R1: A rising edge of `a_cap_clk_i` stores `a_in_i` into the A store, and a rising edge of `b_cap_clk_i` stores `b_in_i` into the B store. Each store holds its value across edges of the other clock.
- R2: Capture takes place under every combination of `en_n_i`, `drive_b_i`, `a2b_stored_i` and `b2a_stored_i`, including isolation.
- R3: With `en_n_i` = 1, both buses are inputs:
  - `a_oe_o` and `b_oe_o` are all zeros.
  - `a_out_o` and `b_out_o` are all zeros.
- R4: With `en_n_i` = 0 and `drive_b_i` = 0, bus A is driven and bus B is not:
  - `a_oe_o` is all ones, and `b_oe_o` and `b_out_o` are all zeros.
  - `a_out_o` is the bitwise complement of `b_in_i` when `b2a_stored_i` = 0, and the complement of the B store when `b2a_stored_i` = 1.
- R5: With `en_n_i` = 0 and `drive_b_i` = 1, bus B is driven and bus A is not:
  - `b_oe_o` is all ones, and `a_oe_o` and `a_out_o` are all zeros.
  - `b_out_o` is the complement of `a_in_i` when `a2b_stored_i` = 0, and the complement of the A store when `a2b_stored_i` = 1.
- R6: The driven output responds in the same cycle, with no clock edge in between, to a change on the live input or on the source select.
- R7: `rst_i` is synchronous and active high.
  - A rising edge of `a_cap_clk_i` with `rst_i` = 1 clears the A store to zero and leaves the B store unchanged; the B clock clears the B store the same way.
  - A cleared store seen on the stored path drives all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_cap_clk_i | input | 1 | Capture clock of the A store |
| b_cap_clk_i | input | 1 | Capture clock of the B store |
| rst_i | input | 1 | Synchronous active-high clear of the store sampled by each clock |
| en_n_i | input | 1 | Active-low output enable; 1 isolates both buses |
| drive_b_i | input | 1 | 0 drives bus A, 1 drives bus B |
| a2b_stored_i | input | 1 | A-to-B source: 0 live `a_in_i`, 1 A store |
| b2a_stored_i | input | 1 | B-to-A source: 0 live `b_in_i`, 1 B store |
| a_in_i | input | W | Bus A input value |
| a_out_o | output | W | Value driven onto bus A |
| a_oe_o | output | W | Per-bit drive enable of bus A |
| b_in_i | input | W | Bus B input value |
| b_out_o | output | W | Value driven onto bus B |
| b_oe_o | output | W | Per-bit drive enable of bus B |

## Verification
The bench builds the block with its defaults: `W` = 8 and the inverting polarity. With only four control bits, all sixteen control combinations can be swept. Each is crossed with a set of data patterns, and one of the two capture clocks is pulsed inside every combination. This puts storage during isolation and storage while the opposite bus is driven within reach. After each step, both stores are read back through the stored path. Reset is then applied on one clock alone, to show that each store is cleared only by its own clock.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    XV_ISOLATE = 2'd0,
    XV_DRIVE_A = 2'd1,
    XV_DRIVE_B = 2'd2
  } xv_mode_e;

  function automatic xv_mode_e xv_decode(input logic en_n, input logic to_b);
    if (en_n) return XV_ISOLATE;
    return to_b ? XV_DRIVE_B : XV_DRIVE_A;
  endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= '0;
    else       q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
  import xcvr_pkg::*;
(
  input  logic en_n_i,
  input  logic drive_b_i,
  output logic drv_a_o,
  output logic drv_b_o
);
  xv_mode_e mode;

  always_comb begin
    mode    = xv_decode(en_n_i, drive_b_i);
    drv_a_o = (mode == XV_DRIVE_A);
    drv_b_o = (mode == XV_DRIVE_B);
  end
endmodule

// File: rtl/xcvr_out_path.sv
module xcvr_out_path #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b1
) (
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  input  logic         use_stored_i,
  input  logic         drive_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] oe_o
);
  logic [W-1:0] src;
  logic [W-1:0] pol;

  assign src = use_stored_i ? stored_i : live_i;

  generate
    if (INVERT) begin : g_inv
      assign pol = ~src;
    end else begin : g_true
      assign pol = src;
    end
  endgenerate

  assign data_o = drive_i ? pol : '0;
  assign oe_o   = {W{drive_i}};
endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b1
) (
  input  logic         a_cap_clk_i,
  input  logic         b_cap_clk_i,
  input  logic         rst_i,
  input  logic         en_n_i,
  input  logic         drive_b_i,
  input  logic         a2b_stored_i,
  input  logic         b2a_stored_i,
  input  logic [W-1:0] a_in_i,
  output logic [W-1:0] a_out_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_in_i,
  output logic [W-1:0] b_out_o,
  output logic [W-1:0] b_oe_o
);
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic         drv_a;
  logic         drv_b;

  xcvr_store_reg #(.W(W)) u_a_store (
    .clk_i(a_cap_clk_i), .rst_i(rst_i), .d_i(a_in_i), .q_o(a_q)
  );

  xcvr_store_reg #(.W(W)) u_b_store (
    .clk_i(b_cap_clk_i), .rst_i(rst_i), .d_i(b_in_i), .q_o(b_q)
  );

  xcvr_mode_dec u_dec (
    .en_n_i(en_n_i), .drive_b_i(drive_b_i), .drv_a_o(drv_a), .drv_b_o(drv_b)
  );

  // B-to-A path feeds bus A
  xcvr_out_path #(.W(W), .INVERT(INVERT)) u_to_a (
    .live_i(b_in_i), .stored_i(b_q), .use_stored_i(b2a_stored_i),
    .drive_i(drv_a), .data_o(a_out_o), .oe_o(a_oe_o)
  );

  // A-to-B path feeds bus B
  xcvr_out_path #(.W(W), .INVERT(INVERT)) u_to_b (
    .live_i(a_in_i), .stored_i(a_q), .use_stored_i(a2b_stored_i),
    .drive_i(drv_b), .data_o(b_out_o), .oe_o(b_oe_o)
  );
endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
  parameter int W = 8
) (
  input logic         a_cap_clk_i,
  input logic         b_cap_clk_i,
  input logic         rst_i,
  input logic         en_n_i,
  input logic         drive_b_i,
  input logic         a2b_stored_i,
  input logic         b2a_stored_i,
  input logic [W-1:0] a_in_i,
  input logic [W-1:0] b_in_i,
  input logic [W-1:0] a_out_o,
  input logic [W-1:0] a_oe_o,
  input logic [W-1:0] b_out_o,
  input logic [W-1:0] b_oe_o,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);
  // R1 / R2: store follows its bus at every edge of its own clock
  a_r1_a_capture: assert property (@(posedge a_cap_clk_i) disable iff (rst_i)
    1'b1 |=> (a_q == $past(a_in_i)));
  a_r1_b_capture: assert property (@(posedge b_cap_clk_i) disable iff (rst_i)
    1'b1 |=> (b_q == $past(b_in_i)));

  // R3: isolation drives nothing
  a_r3_isolate: assert property (@(posedge a_cap_clk_i) disable iff (rst_i)
    en_n_i |-> (a_oe_o == '0 && b_oe_o == '0));

  // R4 / R5: never both buses driven
  a_r4_one_bus: assert property (@(posedge b_cap_clk_i) disable iff (rst_i)
    $onehot0({|a_oe_o, |b_oe_o}));

  // R5: stored A data onto B is complemented
  a_r5_stored_b: assert property (@(posedge a_cap_clk_i) disable iff (rst_i)
    (!en_n_i && drive_b_i && a2b_stored_i) |-> (b_out_o == ~a_q));

  // R4: live B data onto A is complemented
  a_r4_live_a: assert property (@(posedge b_cap_clk_i) disable iff (rst_i)
    (!en_n_i && !drive_b_i && !b2a_stored_i) |-> (a_out_o == ~b_in_i));
endmodule

bind xcvr_regbus xcvr_regbus_chk #(.W(W)) u_chk (
  .a_cap_clk_i(a_cap_clk_i), .b_cap_clk_i(b_cap_clk_i), .rst_i(rst_i),
  .en_n_i(en_n_i), .drive_b_i(drive_b_i), .a2b_stored_i(a2b_stored_i),
  .b2a_stored_i(b2a_stored_i), .a_in_i(a_in_i), .b_in_i(b_in_i),
  .a_out_o(a_out_o), .a_oe_o(a_oe_o), .b_out_o(b_out_o), .b_oe_o(b_oe_o),
  .a_q(a_q), .b_q(b_q)
);

// File: tb/test_xcvr_regbus.sv
module test_xcvr_regbus;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz reference for the watchdog

  logic a_clk = 0, b_clk = 0, rst = 1;
  logic en_n = 1, to_b = 0, a2b_st = 0, b2a_st = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  logic [W-1:0] m_a = '0, m_b = '0;   // bench model of the stores
  int checks = 0, fails = 0;
  bit done = 0;

  xcvr_regbus #(.W(W)) i_xcvr_regbus (
    .a_cap_clk_i(a_clk), .b_cap_clk_i(b_clk), .rst_i(rst),
    .en_n_i(en_n), .drive_b_i(to_b), .a2b_stored_i(a2b_st), .b2a_stored_i(b2a_st),
    .a_in_i(a_in), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    logic [W-1:0] ea, eb, eoa, eob;
    ea = '0; eb = '0; eoa = '0; eob = '0;
    if (!en_n && !to_b) begin
      eoa = '1; ea = ~(b2a_st ? m_b : b_in);
    end else if (!en_n && to_b) begin
      eob = '1; eb = ~(a2b_st ? m_a : a_in);
    end
    #1;
    chk({req, " a_out"}, a_out, ea);
    chk({req, " a_oe"},  a_oe,  eoa);
    chk({req, " b_out"}, b_out, eb);
    chk({req, " b_oe"},  b_oe,  eob);
  endtask

  task automatic pulse_a();
    #2 a_clk = 1;
    m_a = rst ? '0 : a_in;
    #2.5 a_clk = 0; #0.5;
  endtask

  task automatic pulse_b();
    #2 b_clk = 1;
    m_b = rst ? '0 : b_in;
    #2.5 b_clk = 0; #0.5;
  endtask

  // read both stores through the stored paths
  task automatic read_stores(string req);
    en_n = 0; to_b = 1; a2b_st = 1; #1;
    chk({req, " A store"}, b_out, ~m_a);
    to_b = 0; b2a_st = 1; #1;
    chk({req, " B store"}, a_out, ~m_b);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;

    // R7: reset clears both stores; isolation state after reset (R3)
    a_in = 8'h3C; b_in = 8'hC3;
    pulse_a(); pulse_b();
    rst = 0;
    check_outputs("R3 reset isolate");
    read_stores("R7 reset");

    // R1 R2 R3 R4 R5: sweep control x data, capture under each control state
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 6; p++) begin
        a_in = pats[p]; b_in = pats[(p + c) % 6] ^ 8'h96;
        {en_n, to_b, a2b_st, b2a_st} = c[3:0];
        check_outputs("R3/R4/R5 sweep");
        if ((c + p) % 2 == 0) pulse_a(); else pulse_b();
        check_outputs("R2 after capture");
        // R6: live input change with no clock edge
        a_in = ~a_in; b_in = b_in + 8'h11;
        check_outputs("R6 live change");
        // R6: select flip with no clock edge
        a2b_st = ~a2b_st; b2a_st = ~b2a_st;
        check_outputs("R6 select change");
      end
      read_stores("R1 store hold");
    end

    // R1: each store keeps its value across the other clock
    a_in = 8'h12; b_in = 8'h34; pulse_a(); pulse_b();
    a_in = 8'hEE; pulse_b(); read_stores("R1 A holds across B clock");
    b_in = 8'hDD; pulse_a(); read_stores("R1 B holds across A clock");

    // R7: reset on one clock only clears its own store
    a_in = 8'h77; b_in = 8'h66; pulse_a(); pulse_b();
    rst = 1; pulse_a(); rst = 0;
    read_stores("R7 A-only reset");
    en_n = 0; to_b = 1; a2b_st = 1; #1;
    chk("R7 cleared store drives ones", b_out, 8'hFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule